// File: doc/BRIEF.md
# Extended Request Tag Allocator

This block hands out transaction tags to a serial-link requester for its outstanding non-posted requests and takes them back when the matching completions finish. It works in one of two tag spaces. In the narrow space, tags are 8 bits wide, numbered 0..255. In the wide space, tags are 10 bits wide, and every tag whose two upper bits are `00` is withheld. That leaves 768 usable tags, numbered 256..1023. A configuration input picks the space. The active space only changes while nothing is in flight.

Requests use a valid/ready handshake. `req_ready` reflects only the allocator state and the credit limit; it never depends on `req_valid`. A tag moves when `req_valid` and `req_ready` are both high on a clock edge, and `req_tag` carries the lowest free eligible tag in that same cycle. A requester facing a low `req_ready` keeps `req_valid` high and waits. The completion side is a plain strobe that is always accepted. An external non-posted header credit limit caps how many tags may be in flight. Completions that name a tag which is not held, or a withheld tag in the wide space, raise a sticky error flag and change nothing else.

Top module: `xtag_alloc`

## Requirements
- R1: After reset, `outstanding` is 0, `tag_err` is 0, `ext_mode` is 0 (narrow space) and no tag is held.
- R2: In narrow mode (`ext_mode`=0), whenever `req_ready` is high, `req_tag` is the lowest-numbered free tag in 0..255. The tag is taken on a cycle where `req_valid` and `req_ready` are both high.
- R3: In wide mode (`ext_mode`=1), `req_tag` is the lowest-numbered free tag in 256..1023. A tag with `req_tag[9:8]`=00 is never issued, so up to 768 tags can be held.
- R4: `req_ready` is low whenever no eligible tag of the active space is free.
- R5: `req_ready` is low whenever `outstanding` is greater than or equal to `credit_limit`.
- R6: `outstanding` equals the number of held tags. It rises by one per accepted request and falls by one per good final completion.
- R7: A completion with `cpl_valid`=1 and `cpl_last`=1 naming a held tag frees that tag from the next cycle on.
- R8: A completion with `cpl_last`=0 naming a held tag leaves `outstanding`, the held set and `tag_err` unchanged.
- R9: A completion naming a tag that is not held sets `tag_err` and leaves the held set unchanged.
- R10: In wide mode, a completion whose tag has upper bits 00 sets `tag_err` and frees nothing.
- R11: `ext_mode` takes the value of `cfg_ext_en` on a clock edge only if `outstanding` is 0 and no request is accepted on that edge. Otherwise `ext_mode` holds.
- R12: Once set, `tag_err` stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_ext_en | input | 1 | Requested tag space: 1 = wide 10-bit, 0 = narrow 8-bit |
| credit_limit | input | 11 | Maximum number of tags allowed in flight |
| req_valid | input | 1 | Requester wants a tag |
| req_ready | output | 1 | A tag can be issued this cycle |
| req_tag | output | 10 | Tag issued when `req_valid` and `req_ready` are both high |
| cpl_valid | input | 1 | Completion strobe |
| cpl_tag | input | 10 | Tag named by the completion |
| cpl_last | input | 1 | Completion is the final one for its tag |
| ext_mode | output | 1 | Active tag space |
| outstanding | output | 11 | Number of held tags |
| tag_err | output | 1 | Sticky flag for completions with a bad tag |

## Verification
The assertions rely on the inputs following a few rules. Reset is held low for at least one edge before use. `req_valid` may be high or low in any cycle. `cpl_tag` is a fully known value whenever `cpl_valid` is high. Under these rules, the embedded properties on counter agreement, free-tag issue, withheld-tag exclusion, mode stability and sticky error must hold for any completion pattern, including bad ones. The stimulus keeps every input known in every cycle. It steers most completions toward tags the bench model knows are held, and it deliberately injects a small share of stray and withheld tags. It varies the credit limit and toggles the space request during drained stretches, so that mode changes are both taken and refused.

// File: rtl/xtag_pkg.sv
package xtag_pkg;
  // True when a tag index belongs to the active tag space.
  // Wide space excludes indices whose upper bits are all zero.
  function automatic logic tag_in_space(input int unsigned idx,
                                        input logic wide,
                                        input int unsigned narrow_w);
    logic low;
    low = (idx < (32'd1 << narrow_w));
    return wide ? !low : low;
  endfunction
endpackage

// File: rtl/xtag_first_free.sv
module xtag_first_free #(
  parameter int N  = 1024,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  vec,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end
  assign found = |vec;
endmodule

// File: rtl/xtag_store.sv
module xtag_store #(
  parameter int N  = 1024,
  localparam int IW = $clog2(N),
  localparam int CW = $clog2(N + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_en,
  input  logic [IW-1:0] set_idx,
  input  logic          clr_en,
  input  logic [IW-1:0] clr_idx,
  output logic [N-1:0]  held,
  output logic [CW-1:0] count
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held <= '0;
    end else begin
      if (clr_en) held[clr_idx] <= 1'b0;
      if (set_en) held[set_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) count <= '0;
    else begin
      case ({set_en, clr_en})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  AST_CNT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    count == CW'($countones(held))); // R6
  AST_SET_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |-> !held[set_idx]); // R2
  AST_CLR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |-> held[clr_idx]); // R9
endmodule

// File: rtl/xtag_alloc.sv
module xtag_alloc #(
  parameter int TAG_W    = 10,
  parameter int NARROW_W = 8,
  localparam int NTAG    = 1 << TAG_W,
  localparam int CNT_W   = $clog2(NTAG + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_ext_en,
  input  logic [CNT_W-1:0] credit_limit,
  input  logic             req_valid,
  output logic             req_ready,
  output logic [TAG_W-1:0] req_tag,
  input  logic             cpl_valid,
  input  logic [TAG_W-1:0] cpl_tag,
  input  logic             cpl_last,
  output logic             ext_mode,
  output logic [CNT_W-1:0] outstanding,
  output logic             tag_err
);
  import xtag_pkg::*;

  logic [NTAG-1:0]  held;
  logic [NTAG-1:0]  in_space;
  logic [NTAG-1:0]  avail;
  logic             any_free;
  logic [TAG_W-1:0] first_idx;
  logic             xfer;
  logic             cpl_rsvd;
  logic             cpl_bad;
  logic             rel_en;

  for (genvar g = 0; g < NTAG; g++) begin : g_space
    assign in_space[g] = tag_in_space(g, ext_mode, NARROW_W);
  end

  assign avail = in_space & ~held;

  xtag_first_free #(.N(NTAG)) u_pick (
    .vec  (avail),
    .found(any_free),
    .idx  (first_idx)
  );

  assign req_ready = any_free && (outstanding < credit_limit);
  assign req_tag   = first_idx;
  assign xfer      = req_valid && req_ready;

  assign cpl_rsvd = ext_mode && (cpl_tag[TAG_W-1:NARROW_W] == '0);
  assign cpl_bad  = cpl_valid && (!held[cpl_tag] || cpl_rsvd);
  assign rel_en   = cpl_valid && cpl_last && !cpl_bad;

  xtag_store #(.N(NTAG)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_en (xfer),
    .set_idx(first_idx),
    .clr_en (rel_en),
    .clr_idx(cpl_tag),
    .held   (held),
    .count  (outstanding)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)       tag_err <= 1'b0;
    else if (cpl_bad) tag_err <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ext_mode <= 1'b0;
    else if (outstanding == '0 && !xfer) ext_mode <= cfg_ext_en;
  end

  AST_NO_RSVD_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_mode && req_ready) |-> (req_tag[TAG_W-1:NARROW_W] != '0)); // R3
  AST_NARROW_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_mode && req_ready) |-> (req_tag < TAG_W'(1 << NARROW_W))); // R2
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    tag_err |=> tag_err); // R12
  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (outstanding != '0) |=> $stable(ext_mode)); // R11
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    outstanding <= CNT_W'(NTAG - (1 << NARROW_W))); // R3
endmodule

// File: tb/sim_xtag_alloc.sv
`timescale 1ns/1ps
module sim_xtag_alloc;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        cfg_ext_en = 0;
  logic [10:0] credit_limit = 0;
  logic        req_valid = 0;
  logic        req_ready;
  logic [9:0]  req_tag;
  logic        cpl_valid = 0;
  logic [9:0]  cpl_tag = 0;
  logic        cpl_last = 0;
  logic        ext_mode;
  logic [10:0] outstanding;
  logic        tag_err;

  int total = 0, bad = 0;
  bit finished = 0;

  bit m_held [1024];
  int m_cnt;
  bit m_ext, m_err;
  bit e_rdy;
  int e_tag;

  always #2.5 clk = ~clk;

  xtag_alloc u0 (.*);

  task automatic chk(bit ok, string r, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  function automatic int first_free(bit ext);
    for (int i = 0; i < 1024; i++)
      if (!m_held[i] && ((i < 256) != ext)) return i;
    return -1;
  endfunction

  function automatic int pick_held();
    int s = int'($urandom % 1024);
    for (int k = 0; k < 1024; k++)
      if (m_held[(s + k) % 1024]) return (s + k) % 1024;
    return -1;
  endfunction

  task automatic model_reset();
    foreach (m_held[i]) m_held[i] = 0;
    m_cnt = 0; m_ext = 0; m_err = 0;
  endtask

  // One cycle: compare against model, clock, update model.
  task automatic step();
    int ff;
    bit acc, bd, zero_before;
    string lab;
    #1;
    ff = first_free(m_ext);
    e_rdy = (ff >= 0) && (m_cnt < int'(credit_limit));
    e_tag = ff;
    lab = (ff < 0) ? "R4" : (m_cnt >= int'(credit_limit)) ? "R5" : m_ext ? "R3" : "R2";
    chk(req_ready == e_rdy, lab, req_ready, e_rdy);
    if (e_rdy) chk(int'(req_tag) == e_tag, m_ext ? "R3" : "R2", req_tag, e_tag);
    chk(int'(outstanding) == m_cnt, "R6", outstanding, m_cnt);
    chk(tag_err == m_err, "R9", tag_err, m_err);
    chk(ext_mode == m_ext, "R11", ext_mode, m_ext);
    @(posedge clk);
    acc = req_valid && e_rdy;
    zero_before = (m_cnt == 0);
    if (cpl_valid) begin
      bd = !m_held[cpl_tag] || (m_ext && cpl_tag < 256);
      if (bd) m_err = 1;
      else if (cpl_last) begin m_held[cpl_tag] = 0; m_cnt--; end
    end
    if (acc) begin m_held[e_tag] = 1; m_cnt++; end
    if (zero_before && !acc) m_ext = cfg_ext_en;
    @(negedge clk);
  endtask

  task automatic idle();
    req_valid = 0; cpl_valid = 0; cpl_last = 0;
  endtask

  task automatic do_reset();
    rst_n = 0; idle();
    repeat (3) @(negedge clk);
    rst_n = 1; model_reset();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int t;
    do_reset();
    // R1 reset state
    #1;
    chk(outstanding == 0, "R1", outstanding, 0);
    chk(tag_err == 0, "R1", tag_err, 0);
    chk(ext_mode == 0, "R1", ext_mode, 0);
    chk(req_tag == 0, "R1", req_tag, 0);
    @(negedge clk);

    // Narrow mode: take three tags, then R9 stray completion
    credit_limit = 11'd3; cfg_ext_en = 0;
    req_valid = 1; repeat (3) step();
    chk(req_ready == 0, "R5", req_ready, 0); // limit reached
    idle(); cpl_valid = 1; cpl_tag = 10'd77; cpl_last = 1; step();
    idle(); step();
    chk(tag_err == 1 && outstanding == 3, "R9", outstanding, 3);

    // R12 sticky through good traffic
    cpl_valid = 1; cpl_tag = 10'd1; cpl_last = 1; step();
    idle(); step();
    chk(tag_err == 1, "R12", tag_err, 1);
    chk(outstanding == 2, "R7", outstanding, 2);
    req_valid = 1; #1;
    chk(req_tag == 1, "R7", req_tag, 1); // freed tag reused
    step(); idle();

    // R8 non-final completion leaves state alone
    cpl_valid = 1; cpl_tag = 10'd2; cpl_last = 0; step();
    idle(); step();
    chk(outstanding == 3, "R8", outstanding, 3);

    // R11 mode request ignored while tags held
    cfg_ext_en = 1; step(); step();
    chk(ext_mode == 0, "R11", ext_mode, 0);
    for (int k = 0; k < 3; k++) begin
      cpl_valid = 1; cpl_last = 1; cpl_tag = 10'(k); step();
    end
    idle(); step(); step();
    chk(ext_mode == 1, "R11", ext_mode, 1);

    // Wide mode: fill all 768, R4 then R10
    do_reset(); cfg_ext_en = 1; credit_limit = 11'd2047; step();
    req_valid = 1; #1;
    chk(req_tag == 256, "R3", req_tag, 256);
    repeat (768) step();
    idle(); #1;
    chk(outstanding == 768, "R3", outstanding, 768);
    chk(req_ready == 0, "R4", req_ready, 0);
    @(negedge clk);
    cpl_valid = 1; cpl_tag = 10'd5; cpl_last = 1; step();
    idle(); step();
    chk(tag_err == 1 && outstanding == 768, "R10", outstanding, 768);
    cpl_valid = 1; cpl_tag = 10'd300; cpl_last = 1; step();
    idle(); #1;
    chk(req_ready == 1 && req_tag == 300, "R7", req_tag, 300);
    @(negedge clk);

    // Random traffic with fixed seed
    do_reset();
    void'($urandom(32'h5eed_0a11));
    for (int c = 0; c < 6000; c++) begin
      bit drain = ((c / 300) % 3) == 2;
      if (c % 97 == 0) cfg_ext_en = $urandom % 2;
      if (c % 53 == 0) credit_limit = ($urandom % 4 == 0) ? 11'($urandom % 6) : 11'($urandom % 60);
      req_valid = !drain && ($urandom % 10 < 6);
      cpl_valid = 0; cpl_last = 0;
      if (c > 4000 && $urandom % 50 == 0) begin
        cpl_valid = 1; cpl_tag = 10'($urandom); cpl_last = 1;
      end else if ($urandom % 10 < (drain ? 9 : 5)) begin
        t = pick_held();
        if (t >= 0) begin
          cpl_valid = 1; cpl_tag = 10'(t); cpl_last = ($urandom % 4 != 0);
        end
      end
      step();
    end
    idle(); step();

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule